// File: doc/BRIEF.md
# Speculative Last-Value Window

This block is a small, fully associative buffer that sits beside the last-value table of a stride-based value predictor. When a fetch block receives a prediction, its predicted last values are written into the window. A younger instance of the same block can then base its prediction on those in-flight values instead of the stale ones the table still holds. Each lookup port takes a block tag and the table's values for that block. It returns the values of the youngest live window entry whose tag matches, or passes the table's values through when nothing matches. Tags are partial, so an occasional false match is tolerated.

The window is a circular buffer. Allocation writes at the tail and reports the slot number it used. That slot number is the entry's sequence identity. Retirement frees the oldest entry. A squash names a surviving slot and drops every younger entry in one cycle. Lookup port 0 belongs to the block being allocated. Any later lookup port in the same cycle also sees that block's allocation.

Top module: `svw_window`

## Requirements
- R1: When no live entry and no same-cycle allocation matches a lookup tag, that port's `lkHit` is 0 and its `lkVals` equals its `lvtVals` input.
- R2: A lookup whose tag equals the tag of a live entry returns `lkHit`=1 and that entry's stored values, on every lookup port.
- R3: When several live entries match, the most recently allocated one supplies the values.
- R4: An accepted allocation (`allocValid` and `allocReady`) writes slot `allocSlot`, and `allocSlot` then advances by one, modulo DEPTH.
- R5: With DEPTH live entries `allocReady` is 0. An allocation request is then ignored: `allocSlot` does not change and its tag does not hit.
- R6: `retireValid` frees the oldest live entry, which stops hitting from the next cycle. A retire with no live entry has no effect.
- R7: `squashValid` with a live slot `squashSlot` keeps that slot and all older entries and drops all younger ones in one cycle; the next `allocSlot` is `squashSlot`+1 modulo DEPTH. `allocReady` is 0 in a squash cycle. A squash naming a slot that is not live has no effect.
- R8: During an accepted allocation, lookup ports 1 and up whose tag equals `allocTag` return a hit with `allocVals` in the same cycle; port 0 does not see it.
- R9: After reset the window is empty: `allocReady`=1, `allocSlot`=0, and no lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkTag | input | LOOKUPS x TAG_W | Partial block tag per lookup port |
| lvtVals | input | LOOKUPS x (N_VALS*VAL_W) | Last values from the table, per port |
| lkHit | output | LOOKUPS | Window supplied the values |
| lkVals | output | LOOKUPS x (N_VALS*VAL_W) | Freshest last values per port |
| allocValid | input | 1 | Request to add a block entry |
| allocTag | input | TAG_W | Tag of the new entry |
| allocVals | input | N_VALS*VAL_W | Predicted values of the new entry |
| allocReady | output | 1 | Window can accept an allocation |
| allocSlot | output | clog2(DEPTH) | Slot the next allocation uses |
| retireValid | input | 1 | Free the oldest entry |
| squashValid | input | 1 | Drop entries younger than squashSlot |
| squashSlot | input | clog2(DEPTH) | Youngest slot that survives a squash |

## Verification
A wrong head or occupancy count appears at the lookup ports as soon as the next lookup is made. A retired or squashed entry keeps hitting, or a live one stops hitting. It also appears in `allocSlot` and `allocReady` in the cycle right after the faulty update. A wrong age order shows up only when two live entries share a tag, so the bench builds that case on purpose. A lost bypass shows up only on port 1 in the allocation cycle itself.

// File: rtl/svw_pkg.sv
package svw_pkg;
  // strobes from the control half to the storage half
  typedef struct packed {
    logic wrEn;   // write the entry at the tail this cycle
    logic empty;  // no live entry
  } svwStrobes_t;
endpackage

// File: rtl/svw_ctrl.sv
module svw_ctrl #(
  parameter int DEPTH = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   allocValid,
  input  logic                   retireValid,
  input  logic                   squashValid,
  input  logic [IDX_W-1:0]       squashSlot,
  output logic                   allocReady,
  output logic [IDX_W-1:0]       tailIdx,
  output logic [IDX_W-1:0]       headIdx,
  output logic [CNT_W-1:0]       liveCnt,
  output svw_pkg::svwStrobes_t   strobes
);
  logic [IDX_W-1:0] headQ;
  logic [CNT_W-1:0] cntQ;
  logic allocFire, retireFire, squashLive;
  int squashAge, tailSum, nextCnt, nextHead;

  always_comb begin
    tailSum = int'(headQ) + int'(cntQ);
    if (tailSum >= DEPTH) tailSum = tailSum - DEPTH;
    squashAge = int'(squashSlot) - int'(headQ);
    if (squashAge < 0) squashAge = squashAge + DEPTH;
    squashLive = squashValid && (int'(squashSlot) < DEPTH) && (squashAge < int'(cntQ));
    allocReady = (int'(cntQ) < DEPTH) && !squashValid;
    allocFire  = allocValid && allocReady;
    retireFire = retireValid && (cntQ != '0);
    nextCnt = squashLive ? squashAge + 1 : int'(cntQ);
    nextCnt = nextCnt + (allocFire ? 1 : 0) - (retireFire ? 1 : 0);
    nextHead = int'(headQ) + (retireFire ? 1 : 0);
    if (nextHead >= DEPTH) nextHead = 0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      cntQ  <= '0;
    end else begin
      headQ <= IDX_W'(nextHead);
      cntQ  <= CNT_W'(nextCnt);
    end
  end

  assign tailIdx = IDX_W'(tailSum);
  assign headIdx = headQ;
  assign liveCnt = cntQ;
  assign strobes.wrEn  = allocFire;
  assign strobes.empty = (cntQ == '0);
endmodule

// File: rtl/svw_store.sv
module svw_store #(
  parameter int DEPTH   = 32,
  parameter int TAG_W   = 15,
  parameter int VALS_W  = 32,
  parameter int LOOKUPS = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  svw_pkg::svwStrobes_t              strobes,
  input  logic [IDX_W-1:0]                  wrIdx,
  input  logic [IDX_W-1:0]                  headIdx,
  input  logic [CNT_W-1:0]                  liveCnt,
  input  logic [TAG_W-1:0]                  allocTag,
  input  logic [VALS_W-1:0]                 allocVals,
  input  logic [LOOKUPS-1:0][TAG_W-1:0]     lkTag,
  input  logic [LOOKUPS-1:0][VALS_W-1:0]    lvtVals,
  output logic [LOOKUPS-1:0]                lkHit,
  output logic [LOOKUPS-1:0][VALS_W-1:0]    lkVals
);
  logic [TAG_W-1:0]  tagMem [DEPTH];
  logic [VALS_W-1:0] valMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      tagMem[wrIdx] <= allocTag;
      valMem[wrIdx] <= allocVals;
    end
  end

  // distance of a slot from the head: larger means younger
  function automatic int ageOf(input int slot, input int head);
    int a;
    a = slot - head;
    if (a < 0) a = a + DEPTH;
    return a;
  endfunction

  for (genvar p = 0; p < LOOKUPS; p++) begin : g_port
    localparam bit CanBypass = (p > 0);
    logic             winHit, bypass;
    logic [IDX_W-1:0] winIdx;
    int               bestAge, age;

    always_comb begin
      winHit  = 1'b0;
      winIdx  = '0;
      bestAge = 0;
      for (int i = 0; i < DEPTH; i++) begin
        age = ageOf(i, int'(headIdx));
        if (!strobes.empty && age < int'(liveCnt) && tagMem[i] == lkTag[p]
            && (!winHit || age > bestAge)) begin
          winHit  = 1'b1;
          winIdx  = IDX_W'(i);
          bestAge = age;
        end
      end
      bypass = CanBypass && strobes.wrEn && (allocTag == lkTag[p]);
      lkHit[p] = winHit || bypass;
      if (bypass)      lkVals[p] = allocVals;
      else if (winHit) lkVals[p] = valMem[winIdx];
      else             lkVals[p] = lvtVals[p];
    end
  end
endmodule

// File: rtl/svw_window.sv
module svw_window #(
  parameter int DEPTH   = 32,
  parameter int TAG_W   = 15,
  parameter int N_VALS  = 2,
  parameter int VAL_W   = 16,
  parameter int LOOKUPS = 2,
  localparam int VALS_W = N_VALS * VAL_W,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [LOOKUPS-1:0][TAG_W-1:0]  lkTag,
  input  logic [LOOKUPS-1:0][VALS_W-1:0] lvtVals,
  output logic [LOOKUPS-1:0]             lkHit,
  output logic [LOOKUPS-1:0][VALS_W-1:0] lkVals,
  input  logic                           allocValid,
  input  logic [TAG_W-1:0]               allocTag,
  input  logic [VALS_W-1:0]              allocVals,
  output logic                           allocReady,
  output logic [IDX_W-1:0]               allocSlot,
  input  logic                           retireValid,
  input  logic                           squashValid,
  input  logic [IDX_W-1:0]               squashSlot
);
  svw_pkg::svwStrobes_t strobes;
  logic [IDX_W-1:0] headIdx;
  logic [CNT_W-1:0] liveCnt;

  svw_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .retireValid(retireValid),
    .squashValid(squashValid), .squashSlot(squashSlot),
    .allocReady(allocReady), .tailIdx(allocSlot),
    .headIdx(headIdx), .liveCnt(liveCnt), .strobes(strobes)
  );

  svw_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .VALS_W(VALS_W), .LOOKUPS(LOOKUPS)) u_store (
    .clk(clk), .strobes(strobes), .wrIdx(allocSlot),
    .headIdx(headIdx), .liveCnt(liveCnt),
    .allocTag(allocTag), .allocVals(allocVals),
    .lkTag(lkTag), .lvtVals(lvtVals),
    .lkHit(lkHit), .lkVals(lkVals)
  );
endmodule

// File: rtl/svw_check.sv
module svw_check #(
  parameter int DEPTH   = 32,
  parameter int TAG_W   = 15,
  parameter int N_VALS  = 2,
  parameter int VAL_W   = 16,
  parameter int LOOKUPS = 2,
  localparam int VALS_W = N_VALS * VAL_W,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [LOOKUPS-1:0][TAG_W-1:0]  lkTag,
  input logic [LOOKUPS-1:0][VALS_W-1:0] lvtVals,
  input logic [LOOKUPS-1:0]             lkHit,
  input logic [LOOKUPS-1:0][VALS_W-1:0] lkVals,
  input logic                           allocValid,
  input logic [TAG_W-1:0]               allocTag,
  input logic [VALS_W-1:0]              allocVals,
  input logic                           allocReady,
  input logic [IDX_W-1:0]               allocSlot,
  input logic                           retireValid,
  input logic                           squashValid,
  input logic [IDX_W-1:0]               squashSlot
);
  // occupancy mirror built from the port traffic only
  int mHead, mCnt, sqAge, nCnt, nHead;
  logic sqLive;

  always_comb begin
    sqAge = int'(squashSlot) - mHead;
    if (sqAge < 0) sqAge = sqAge + DEPTH;
    sqLive = squashValid && int'(squashSlot) < DEPTH && sqAge < mCnt;
    nCnt = sqLive ? sqAge + 1 : mCnt;
    nCnt = nCnt + ((allocValid && allocReady) ? 1 : 0) - ((retireValid && mCnt > 0) ? 1 : 0);
    nHead = mHead + ((retireValid && mCnt > 0) ? 1 : 0);
    if (nHead >= DEPTH) nHead = 0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mHead <= 0;
      mCnt  <= 0;
    end else begin
      mHead <= nHead;
      mCnt  <= nCnt;
    end
  end

  function automatic logic [IDX_W-1:0] stepSlot(input logic [IDX_W-1:0] s);
    return (int'(s) + 1 >= DEPTH) ? '0 : IDX_W'(int'(s) + 1);
  endfunction

  p_miss_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit[0] |-> lkVals[0] == lvtVals[0]);
  p_slot_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocReady) |=> allocSlot == stepSlot($past(allocSlot)));
  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mCnt == DEPTH) |-> !allocReady);
  p_squash_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |-> !allocReady);
  p_squash_tail_r7: assert property (@(posedge clk) disable iff (!rstN)
    sqLive |=> allocSlot == stepSlot($past(squashSlot)));
  p_empty_miss_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mCnt == 0) |-> !lkHit[0]);

  if (LOOKUPS > 1) begin : g_byp
    p_bypass_r8: assert property (@(posedge clk) disable iff (!rstN)
      (allocValid && allocReady && lkTag[1] == allocTag) |-> (lkHit[1] && lkVals[1] == allocVals));
  end
endmodule

bind svw_window svw_check #(.DEPTH(DEPTH), .TAG_W(TAG_W), .N_VALS(N_VALS), .VAL_W(VAL_W), .LOOKUPS(LOOKUPS)) u_check (.*);

// File: tb/svw_window_test.sv
module svw_window_test;
  localparam int DEPTH = 32, TAG_W = 15, VALS_W = 32, LOOKUPS = 2, IDX_W = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic [LOOKUPS-1:0][TAG_W-1:0]  lkTag;
  logic [LOOKUPS-1:0][VALS_W-1:0] lvtVals, lkVals;
  logic [LOOKUPS-1:0]             lkHit;
  logic allocValid, allocReady, retireValid, squashValid;
  logic [TAG_W-1:0]  allocTag;
  logic [VALS_W-1:0] allocVals;
  logic [IDX_W-1:0]  allocSlot, squashSlot;

  svw_window uut (.*);

  typedef struct {
    int kind;            // 0 lookup, 1 ready, 2 slot
    int port;
    logic expHit;
    logic [VALS_W-1:0] expVal;
    int expInt;
    string req;
  } item_t;

  item_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model: live entries, oldest first
  logic [TAG_W-1:0]  mTag[$];
  logic [VALS_W-1:0] mVal[$];
  int mTail = 0;

  function automatic int headSlot();
    return (mTail - mTag.size() + DEPTH) % DEPTH;
  endfunction

  function automatic bit allocFires();
    return allocValid && !squashValid && (mTag.size() < DEPTH);
  endfunction

  task automatic look(input int p, input logic [TAG_W-1:0] t, input logic [VALS_W-1:0] lvt, input string req);
    item_t it;
    lkTag[p] = t;
    lvtVals[p] = lvt;
    it.kind = 0; it.port = p; it.req = req; it.expInt = 0;
    it.expHit = 1'b0; it.expVal = lvt;
    for (int i = 0; i < mTag.size(); i++)
      if (mTag[i] == t) begin it.expHit = 1'b1; it.expVal = mVal[i]; end
    if (p == 1 && allocFires() && allocTag == t) begin it.expHit = 1'b1; it.expVal = allocVals; end
    sb.push_back(it);
  endtask

  task automatic ctl(input string req);
    item_t it;
    it.port = 0; it.expHit = 1'b0; it.expVal = '0; it.req = req;
    it.kind = 1; it.expInt = (mTag.size() < DEPTH && !squashValid) ? 1 : 0;
    sb.push_back(it);
    it.kind = 2; it.expInt = mTail;
    sb.push_back(it);
  endtask

  task automatic step();
    bit af, rf;
    int age;
    @(posedge clk);
    af = allocFires();
    rf = retireValid && (mTag.size() > 0);
    if (squashValid) begin
      age = (int'(squashSlot) - headSlot() + DEPTH) % DEPTH;
      if (age < mTag.size()) begin
        while (mTag.size() > age + 1) begin void'(mTag.pop_back()); void'(mVal.pop_back()); end
        mTail = (int'(squashSlot) + 1) % DEPTH;
      end
    end
    if (rf) begin void'(mTag.pop_front()); void'(mVal.pop_front()); end
    if (af) begin mTag.push_back(allocTag); mVal.push_back(allocVals); mTail = (mTail + 1) % DEPTH; end
    #1;
    allocValid = 0; retireValid = 0; squashValid = 0;
  endtask

  // monitor: compare every queued expectation before the next edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.kind == 0) begin
        if (lkHit[it.port] !== it.expHit || lkVals[it.port] !== it.expVal) begin
          errors++;
          $display("FAIL %s port%0d hit=%0b vals=%h expected hit=%0b vals=%h",
                   it.req, it.port, lkHit[it.port], lkVals[it.port], it.expHit, it.expVal);
        end
      end else if (it.kind == 1) begin
        if (int'(allocReady) != it.expInt) begin
          errors++;
          $display("FAIL %s allocReady=%0d expected %0d", it.req, allocReady, it.expInt);
        end
      end else begin
        if (int'(allocSlot) != it.expInt) begin
          errors++;
          $display("FAIL %s allocSlot=%0d expected %0d", it.req, allocSlot, it.expInt);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; allocValid = 0; retireValid = 0; squashValid = 0;
    allocTag = '0; allocVals = '0; squashSlot = '0; lkTag = '0; lvtVals = '0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;

    // R9 reset state, R1 pass-through
    ctl("R9");
    look(0, 15'h011, 32'hAAAA_0000, "R9");
    look(1, 15'h022, 32'hBBBB_0000, "R1");
    step();

    // R8: allocation visible to port 1 only
    allocValid = 1; allocTag = 15'h011; allocVals = 32'h1111_2222;
    ctl("R4");
    look(0, 15'h011, 32'hAAAA_0001, "R8");
    look(1, 15'h011, 32'hBBBB_0001, "R8");
    step();

    // R2 hit; R1 miss on the other port; allocate B
    allocValid = 1; allocTag = 15'h033; allocVals = 32'h3333_4444;
    ctl("R4");
    look(0, 15'h011, 32'hAAAA_0002, "R2");
    look(1, 15'h044, 32'hBBBB_0002, "R1");
    step();

    // second copy of tag 011; port 0 still sees the older copy this cycle
    allocValid = 1; allocTag = 15'h011; allocVals = 32'h5555_6666;
    look(0, 15'h011, 32'hAAAA_0003, "R8");
    look(1, 15'h033, 32'hBBBB_0003, "R2");
    step();

    // R3 youngest wins
    look(0, 15'h011, 32'hAAAA_0004, "R3");
    look(1, 15'h011, 32'hBBBB_0004, "R3");
    ctl("R4");
    step();

    // fill to DEPTH
    for (int k = 3; k < DEPTH; k++) begin
      allocValid = 1; allocTag = TAG_W'(15'h100 + k); allocVals = 32'hC000_0000 + k;
      step();
    end
    ctl("R5");
    allocValid = 1; allocTag = 15'h7FF; allocVals = 32'hDEAD_0001;
    look(1, 15'h7FF, 32'hBBBB_0005, "R5");
    ctl("R5");
    step();
    look(0, 15'h7FF, 32'hAAAA_0006, "R5");
    look(1, 15'h103, 32'hBBBB_0006, "R2");
    ctl("R5");
    step();

    // R6 retire three oldest
    for (int k = 0; k < 3; k++) begin retireValid = 1; step(); end
    look(0, 15'h011, 32'hAAAA_0007, "R6");
    look(1, 15'h033, 32'hBBBB_0007, "R6");
    ctl("R6");
    step();

    // R7 squash keeping slot 10, alloc in same cycle ignored
    squashValid = 1; squashSlot = 5'd10;
    allocValid = 1; allocTag = 15'h055; allocVals = 32'h5555_0000;
    ctl("R7");
    step();
    look(0, 15'h10B, 32'hAAAA_0008, "R7");
    look(1, 15'h10A, 32'hBBBB_0008, "R7");
    ctl("R7");
    step();
    look(0, 15'h055, 32'hAAAA_0009, "R7");
    step();

    // R7 squash of a slot that is not live
    squashValid = 1; squashSlot = 5'd20;
    step();
    ctl("R7");
    look(0, 15'h10A, 32'hAAAA_000A, "R7");
    look(1, 15'h104, 32'hBBBB_000A, "R7");
    step();

    // R6 drain, with two retires on an empty window
    for (int k = 0; k < 10; k++) begin retireValid = 1; step(); end
    ctl("R6");
    look(0, 15'h103, 32'hAAAA_000B, "R6");
    step();
    allocValid = 1; allocTag = 15'h066; allocVals = 32'h6666_7777;
    step();
    look(0, 15'h066, 32'hAAAA_000C, "R4");
    ctl("R4");
    step();
    step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule